// File: doc/BRIEF.md
# GPIO Pin Interrupt Detection Unit

This block watches every input pin of one GPIO port and turns configured pin activity into interrupt events. Each pin is brought into the clock domain through a two-stage synchronizer. It is then checked for a level condition or an edge condition, chosen per pin. A detected condition sets a sticky per-pin status bit. The status bit is set whether or not the pin's interrupt is enabled, so software can poll the status even for pins that do not interrupt.

The port produces two requests. The first is a one-cycle interrupt pulse, raised when an enabled pin's status bit goes from clear to set. The second is a wakeup level, raised while any enabled, edge-configured pin has a pending status bit. Level-configured pins never take part in wakeup.

Software reaches the block through a simple register port. A single-cycle write strobe carries an address and data word with one bit per pin. A combinational read port returns the register selected by its address. Writing ones to the clear register drops status bits and rearms the edge detectors of those pins.

Top module: `gpio_irq_unit`

## Requirements
- R1: A pin's status bit (read at address 5, bit n = pin n) sets when that pin's configured trigger occurs, whatever the pin's enable bit (address 0) holds, and stays set until cleared.
- R2: `irq_o` is high for exactly one cycle, in the cycle where an enabled pin's status bit first reads 1; it does not pulse for disabled pins or for status bits that were already set.
- R3: Writing 0 to a pin's enable bit stops further interrupt pulses from that pin but leaves its pending status bit set.
- R4: Writing 1 to bit n of the clear register (address 1, reads back 0) clears status bit n; a 0 in the written word leaves that status bit unchanged.
- R5: With the mode bit (address 2) at 0 the pin is level triggered: polarity (address 3) 0 triggers on a high input, 1 on a low input; a status bit cleared while the active level persists reads 1 again on the next cycle.
- R6: With the mode bit at 1 the pin is edge triggered: polarity 0 triggers on a rising transition, polarity 1 on a falling one.
- R7: With the dual bit (address 4) at 1, an edge-mode pin triggers on both rising and falling transitions, regardless of polarity.
- R8: `wake_o` is high while any pin with enable 1 and mode 1 has its status bit set; pins in level mode never raise it.
- R9: When a clear write and a new trigger hit the same pin in the same cycle, the status bit stays set.
- R10: A pin change driven between clock edges sets its status bit at the third following rising edge and not earlier (two synchronizer stages plus the status register).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pin_i | input | NPINS | Asynchronous pin inputs |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Write register address |
| wr_data_i | input | NPINS | Write data, one bit per pin |
| rd_addr_i | input | 3 | Read register address |
| rd_data_o | output | NPINS | Read data for rd_addr_i |
| irq_o | output | 1 | One-cycle port interrupt pulse |
| wake_o | output | 1 | Wakeup request from edge-mode pins |

## Verification
The bench builds the block with NPINS at 8. This keeps the read words short while still giving enough pins to run a level-mode pin, an edge-mode pin and a dual-edge pin side by side. It also places a disabled pin next to enabled ones, so any cross-pin leakage of interrupt or wakeup shows up at the ports. Each scenario drives pins between clock edges, so the exact three-edge latency from pin to status and to the interrupt pulse can be pinned down cycle by cycle.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  localparam int ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    REG_ENABLE = 3'd0,
    REG_CLEAR  = 3'd1,
    REG_MODE   = 3'd2,
    REG_POL    = 3'd3,
    REG_DUAL   = 3'd4,
    REG_STATUS = 3'd5
  } reg_addr_e;

  // Trigger decision for one pin from its current and previous sampled value.
  function automatic logic trig_hit(input logic cur, input logic prv,
                                    input logic edge_mode, input logic pol,
                                    input logic dual);
    logic rise, fall;
    rise = cur & ~prv;
    fall = ~cur & prv;
    if (!edge_mode) return pol ? ~cur : cur;
    if (dual)       return rise | fall;
    return pol ? fall : rise;
  endfunction
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int WIDTH  = 32,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) stage_q[s] <= '0;
    end else begin
      stage_q[0] <= d_i;
      for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_pin_detect.sv
module gpio_pin_detect
  import gpio_irq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic sync_i,
  input  logic clr_i,
  input  logic mode_i,
  input  logic pol_i,
  input  logic dual_i,
  output logic evt_o,
  output logic rise_o,
  output logic stat_o
);
  logic prev_q;
  logic stat_q;
  logic evt;

  assign evt = trig_hit(sync_i, prev_q, mode_i, pol_i, dual_i);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      stat_q <= 1'b0;
    end else begin
      // The previous-value register tracks every cycle; a clear therefore
      // leaves the detector armed against the value now present.
      prev_q <= sync_i;
      stat_q <= (stat_q & ~clr_i) | evt;
    end
  end

  assign evt_o  = evt;
  assign rise_o = evt & ~stat_q;
  assign stat_o = stat_q;

  // R1
  status_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_q && !clr_i) |=> stat_q);
  // R4
  clear_drops_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !evt) |=> !stat_q);
  // R9
  event_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt |=> stat_q);
endmodule

// File: rtl/gpio_irq_unit.sv
module gpio_irq_unit
  import gpio_irq_pkg::*;
#(
  parameter int NPINS = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] pin_i,
  input  logic             wr_en_i,
  input  logic [2:0]       wr_addr_i,
  input  logic [NPINS-1:0] wr_data_i,
  input  logic [2:0]       rd_addr_i,
  output logic [NPINS-1:0] rd_data_o,
  output logic             irq_o,
  output logic             wake_o
);
  logic [NPINS-1:0] en_q, mode_q, pol_q, dual_q;
  logic [NPINS-1:0] sync_w, clr_w, evt_w, rise_w, stat_w;
  logic             irq_q;

  gpio_sync #(.WIDTH(NPINS), .STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_i(pin_i), .q_o(sync_w)
  );

  assign clr_w = (wr_en_i && wr_addr_i == REG_CLEAR) ? wr_data_i : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q   <= '0;
      mode_q <= '0;
      pol_q  <= '0;
      dual_q <= '0;
    end else if (wr_en_i) begin
      case (wr_addr_i)
        REG_ENABLE: en_q   <= wr_data_i;
        REG_MODE:   mode_q <= wr_data_i;
        REG_POL:    pol_q  <= wr_data_i;
        REG_DUAL:   dual_q <= wr_data_i;
        default: ;
      endcase
    end
  end

  for (genvar p = 0; p < NPINS; p++) begin : g_pin
    gpio_pin_detect u_det (
      .clk(clk), .rst_n(rst_n), .sync_i(sync_w[p]), .clr_i(clr_w[p]),
      .mode_i(mode_q[p]), .pol_i(pol_q[p]), .dual_i(dual_q[p]),
      .evt_o(evt_w[p]), .rise_o(rise_w[p]), .stat_o(stat_w[p])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= |(rise_w & en_q);
  end

  assign irq_o  = irq_q;
  assign wake_o = |(stat_w & en_q & mode_q);

  always_comb begin
    case (rd_addr_i)
      REG_ENABLE: rd_data_o = en_q;
      REG_MODE:   rd_data_o = mode_q;
      REG_POL:    rd_data_o = pol_q;
      REG_DUAL:   rd_data_o = dual_q;
      REG_STATUS: rd_data_o = stat_w;
      default:    rd_data_o = '0;
    endcase
  end

  // R2
  irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> |(stat_w & $past(en_q) & ~$past(stat_w)));
  // R2
  irq_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |=> !irq_o || |(stat_w & $past(en_q) & ~$past(stat_w)));
  // R8
  wake_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == '0) |-> !wake_o);
endmodule

// File: tb/tb_gpio_irq_unit.sv
module tb_gpio_irq_unit;
  localparam int NPINS = 8;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [NPINS-1:0] pin_i = '0;
  logic             wr_en_i = 1'b0;
  logic [2:0]       wr_addr_i = '0;
  logic [NPINS-1:0] wr_data_i = '0;
  logic [2:0]       rd_addr_i = '0;
  logic [NPINS-1:0] rd_data_o;
  logic             irq_o, wake_o;

  int checks = 0;
  int fails  = 0;
  int irq_cnt = 0;

  gpio_irq_unit #(.NPINS(NPINS)) dut (
    .clk(clk), .rst_n(rst_n), .pin_i(pin_i), .wr_en_i(wr_en_i),
    .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i), .rd_addr_i(rd_addr_i),
    .rd_data_o(rd_data_o), .irq_o(irq_o), .wake_o(wake_o)
  );

  always #5 clk = ~clk;

  always @(posedge clk) if (rst_n && irq_o) irq_cnt++;

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [NPINS-1:0] d);
    @(negedge clk);
    wr_en_i = 1'b1; wr_addr_i = a; wr_data_i = d;
    @(negedge clk);
    wr_en_i = 1'b0; wr_data_i = '0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [NPINS-1:0] d);
    rd_addr_i = a;
    #1;
    d = rd_data_o;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic clear_all();
    wr(3'd1, '1);
    idle(1);
  endtask

  task automatic t_reset();
    logic [NPINS-1:0] d;
    rd(3'd5, d); check("R1 reset status", d, 0);
    rd(3'd0, d); check("R3 reset enable", d, 0);
    check("R2 reset irq", irq_o, 0);
    check("R8 reset wake", wake_o, 0);
  endtask

  // Level high on a disabled pin: status sets, no irq, clear re-sets.
  task automatic t_level_disabled();
    logic [NPINS-1:0] d;
    int c0;
    c0 = irq_cnt;
    @(negedge clk); pin_i[0] = 1'b1;
    @(negedge clk); @(negedge clk);
    rd(3'd5, d); check("R10 not before third edge", d[0], 0);
    @(negedge clk);
    rd(3'd5, d); check("R10 status at third edge", d[0], 1);
    check("R1 status while disabled", d[0], 1);
    idle(2);
    check("R2 no irq when disabled", irq_cnt - c0, 0);
    check("R8 level pin no wake", wake_o, 0);
    wr(3'd1, 8'h00);
    rd(3'd5, d); check("R4 zero write keeps", d[0], 1);
    // Clear coincides with the held level event.
    wr(3'd1, 8'h01);
    rd(3'd5, d); check("R9 clear vs event", d[0], 1);
    check("R5 level re-sets", d[0], 1);
    @(negedge clk); pin_i[0] = 1'b0;
    idle(4);
    wr(3'd1, 8'h01);
    rd(3'd5, d); check("R4 clear drops", d[0], 0);
    rd(3'd1, d); check("R4 clear reads zero", d, 0);
  endtask

  // Level-low trigger with polarity 1.
  task automatic t_level_low();
    logic [NPINS-1:0] d;
    wr(3'd3, 8'h02);
    idle(4);
    rd(3'd5, d); check("R5 low level triggers", d[1], 1);
    wr(3'd3, 8'h00);
    @(negedge clk); pin_i[1] = 1'b1;
    idle(4);
    wr(3'd1, 8'h02);
    idle(2);
    rd(3'd5, d); check("R5 pol0 high", d[1], 1);
    @(negedge clk); pin_i[1] = 1'b0;
    idle(4);
    clear_all();
    rd(3'd5, d); check("R5 cleared once inactive", d[1], 0);
  endtask

  // Rising edge on enabled pin 2.
  task automatic t_edge_rise();
    logic [NPINS-1:0] d;
    int c0;
    wr(3'd2, 8'h04);
    wr(3'd0, 8'h04);
    clear_all();
    c0 = irq_cnt;
    @(negedge clk); pin_i[2] = 1'b1;
    idle(2);
    check("R2 no irq before status", irq_o, 0);
    @(negedge clk);
    check("R2 irq with status", irq_o, 1);
    rd(3'd5, d); check("R6 rise sets", d[2], 1);
    idle(4);
    check("R2 single pulse", irq_cnt - c0, 1);
    check("R8 wake edge pin", wake_o, 1);
    wr(3'd1, 8'h04);
    idle(3);
    rd(3'd5, d); check("R6 held high no retrigger", d[2], 0);
    check("R8 wake drops", wake_o, 0);
    @(negedge clk); pin_i[2] = 1'b0;
    idle(4);
    rd(3'd5, d); check("R6 fall ignored pol0", d[2], 0);
  endtask

  // Falling edge with polarity 1, then disable keeps pending.
  task automatic t_edge_fall();
    logic [NPINS-1:0] d;
    int c0;
    wr(3'd3, 8'h04);
    @(negedge clk); pin_i[2] = 1'b1;
    idle(4);
    rd(3'd5, d); check("R6 rise ignored pol1", d[2], 0);
    c0 = irq_cnt;
    @(negedge clk); pin_i[2] = 1'b0;
    idle(4);
    rd(3'd5, d); check("R6 fall sets pol1", d[2], 1);
    check("R2 fall irq", irq_cnt - c0, 1);
    wr(3'd0, 8'h00);
    idle(2);
    rd(3'd5, d); check("R3 pending kept", d[2], 1);
    wr(3'd1, 8'h04);
    c0 = irq_cnt;
    @(negedge clk); pin_i[2] = 1'b1;
    @(negedge clk); pin_i[2] = 1'b0;
    idle(5);
    rd(3'd5, d); check("R3 status still latches", d[2], 1);
    check("R3 no irq when disabled", irq_cnt - c0, 0);
    wr(3'd3, 8'h00);
    clear_all();
  endtask

  // Dual edge on pin 3 with polarity 1.
  task automatic t_dual();
    logic [NPINS-1:0] d;
    int c0;
    wr(3'd2, 8'h08);
    wr(3'd3, 8'h08);
    wr(3'd4, 8'h08);
    wr(3'd0, 8'h08);
    clear_all();
    c0 = irq_cnt;
    @(negedge clk); pin_i[3] = 1'b1;
    idle(4);
    rd(3'd5, d); check("R7 rise with dual", d[3], 1);
    wr(3'd1, 8'h08);
    idle(2);
    @(negedge clk); pin_i[3] = 1'b0;
    idle(4);
    rd(3'd5, d); check("R7 fall with dual", d[3], 1);
    check("R7 two irqs", irq_cnt - c0, 2);
    check("R8 wake dual", wake_o, 1);
  endtask

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(1);
    t_reset();
    t_level_disabled();
    t_level_low();
    t_edge_rise();
    t_edge_fall();
    t_dual();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    #1_000_000;
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule